// File: doc/BRIEF.md
# Unrouted Switch Tracker

During one layer of path-chasing permutation routing, the router must repeatedly find an output switch that no path has touched yet, to start a fresh loop. This block keeps every not-yet-visited switch of the layer in a doubly linked list held in ascending index order. Each entry stores a successor index and a predecessor index. Removing an entry joins its two neighbours to each other, so the next free origin is read from a head register in constant time. No priority encoder is involved.

The router loads the list with the layer's switch count. Switch 0 is never placed in the list, because it is always the first origin. After that the router marks switches as used through an eject port, which accepts any index, or through a head-read strobe, which consumes the current head. Each accepted removal appears on the outputs one clock later. When the list runs empty, `all_done` reports that every loop of the layer is closed.

The control is a three-state machine. `TRK_IDLE` lasts from reset until the first load. `TRK_ACTIVE` holds while the list has entries. `TRK_DONE` holds once the list is empty. The transitions are:
- LOAD_FILL: any state to `TRK_ACTIVE`, on a load with an effective count of 2 or more.
- LOAD_EMPTY: any state to `TRK_DONE`, on a load with an effective count of 0 or 1.
- DRAIN_LAST: `TRK_ACTIVE` to `TRK_DONE`, when the only remaining entry is removed.

The end-of-list sentinel is the value `MAX_SW`.

Top module: `unrouted_switch_tracker`

## Requirements
- R1: After reset, `head` equals the sentinel `MAX_SW`, and `head_valid` and `all_done` are both 0.
- R2: A load with count C uses an effective count E = min(C, MAX_SW). One cycle after the load, the list holds indices 1 to E-1. If E is 2 or more, then `head`=1 and `head_valid`=1. If E is 0 or 1, then `head`=sentinel, `head_valid`=0 and `all_done`=1.
- R3: A head-read while `head_valid`=1 removes the head. One cycle later, `head` shows the smallest remaining index.
- R4: An eject of a listed index removes only that entry. Every later head value skips it, and all other entries remain in ascending order.
- R5: An eject is ignored, with no change to `head` or to the remaining list, when its index is 0, is not below E, or was already removed.
- R6: An eject whose index equals the current head advances `head` exactly as a head-read does.
- R7: If eject and head-read are asserted in the same cycle, only the eject is served and the head-read is dropped.
- R8: Between two loads, `head` never decreases.
- R9: A load takes priority over an eject or head-read in the same cycle, and rebuilds the whole list.
- R10: When the last entry is removed, `all_done` becomes 1, `head_valid` becomes 0 and `head` becomes the sentinel. Ejects and head-reads have no effect until the next load.
- R11: Before the first load, ejects and head-reads have no effect, and the outputs stay at their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_valid | input | 1 | Load the list from `init_count` |
| init_count | input | IDX_W | Number of output switches in the layer |
| eject_valid | input | 1 | Remove the entry named by `eject_idx` |
| eject_idx | input | IDX_W | Switch index to remove |
| head_rd | input | 1 | Consume the current head |
| head | output | IDX_W | Smallest unrouted switch index, or sentinel `MAX_SW` |
| head_valid | output | 1 | List is non-empty |
| all_done | output | 1 | List has been loaded and is now empty |

## Verification
The assertions assume that `rst_n` is asserted before the first clock edge and that only whole cycles of input are presented. They place no restriction on combinations of inputs. Ejects of unlisted, repeated, zero or out-of-range indices, simultaneous requests, and requests made before the first load are all legal, and the stimulus deliberately includes every one of them. With eight switches, the bench drives every subset of ejected entries, mixes in illegal indices, and then drains the list by head-reads. For each cycle it compares the outputs against a bit-set model whose expected head is the lowest set bit.

// File: rtl/trk_pkg.sv
package trk_pkg;
    typedef enum logic [1:0] {
        TRK_IDLE   = 2'd0,
        TRK_ACTIVE = 2'd1,
        TRK_DONE   = 2'd2
    } trk_state_e;
endpackage

// File: rtl/tracker_link_store.sv
module tracker_link_store #(
    parameter int MAX_SW = 32,
    parameter int IDX_W  = $clog2(MAX_SW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_cnt,
    input  logic             unlink_en,
    input  logic [IDX_W-1:0] unlink_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_live,
    output logic [IDX_W-1:0] rd_next,
    output logic [IDX_W-1:0] rd_prev
);
    localparam logic [IDX_W-1:0] NIL = IDX_W'(MAX_SW);

    logic [MAX_SW-1:0] live;
    logic [IDX_W-1:0]  nxt [MAX_SW];
    logic [IDX_W-1:0]  prv [MAX_SW];
    logic [MAX_SW-1:0] front;

    // Neighbours of the entry being removed, used by every entry's update
    logic [IDX_W-1:0]  cut_next, cut_prev;
    assign cut_next = rd_next;
    assign cut_prev = rd_prev;

    for (genvar g = 0; g < MAX_SW; g++) begin : g_entry
        localparam logic [IDX_W-1:0] ME   = IDX_W'(g);
        localparam logic [IDX_W-1:0] SUCC = IDX_W'(g + 1);
        localparam logic [IDX_W-1:0] PRED = (g >= 2) ? IDX_W'(g - 1) : NIL;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live[g] <= 1'b0;
                nxt[g]  <= NIL;
                prv[g]  <= NIL;
            end else if (load) begin
                live[g] <= (g >= 1) && (ME < load_cnt);
                nxt[g]  <= (SUCC < load_cnt) ? SUCC : NIL;
                prv[g]  <= PRED;
            end else if (unlink_en) begin
                if (unlink_idx == ME) live[g] <= 1'b0;
                if (cut_prev == ME)   nxt[g]  <= cut_next;
                if (cut_next == ME)   prv[g]  <= cut_prev;
            end
        end

        assign front[g] = live[g] && (prv[g] == NIL);
    end

    always_comb begin
        rd_live = 1'b0;
        rd_next = NIL;
        rd_prev = NIL;
        for (int k = 0; k < MAX_SW; k++) begin
            if (IDX_W'(k) == rd_idx) begin
                rd_live = live[k];
                rd_next = nxt[k];
                rd_prev = prv[k];
            end
        end
    end

    // Ordered list has at most one entry without a predecessor
    assert_single_front_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(front));

    // A removed entry is no longer listed on the following cycle
    assert_unlinked_gone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (unlink_en && !load) |=> !(rd_live && rd_idx == $past(unlink_idx)));
endmodule

// File: rtl/tracker_fsm.sv
module tracker_fsm
    import trk_pkg::*;
#(
    parameter int MAX_SW = 32,
    parameter int IDX_W  = $clog2(MAX_SW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_valid,
    input  logic [IDX_W-1:0] init_count,
    input  logic             eject_valid,
    input  logic [IDX_W-1:0] eject_idx,
    input  logic             head_rd,
    input  logic             rd_live,
    input  logic [IDX_W-1:0] rd_next,
    input  logic [IDX_W-1:0] rd_prev,
    output logic             load,
    output logic [IDX_W-1:0] load_cnt,
    output logic             unlink_en,
    output logic [IDX_W-1:0] unlink_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic [IDX_W-1:0] head,
    output logic             head_valid,
    output logic             all_done
);
    localparam logic [IDX_W-1:0] NIL = IDX_W'(MAX_SW);
    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    trk_state_e       state_q, state_d;
    logic [IDX_W-1:0] head_q, head_d;
    logic             removes_front;

    assign load     = init_valid;
    assign load_cnt = (init_count > NIL) ? NIL : init_count;

    // The eject port wins over head-read
    assign rd_idx     = eject_valid ? eject_idx : head_q;
    assign unlink_idx = rd_idx;
    assign unlink_en  = (state_q == TRK_ACTIVE) && !init_valid
                        && (eject_valid || head_rd) && rd_live;
    assign removes_front = unlink_en && (rd_prev == NIL);

    always_comb begin
        state_d = state_q;
        head_d  = head_q;
        if (init_valid) begin
            if (load_cnt > ONE) begin
                state_d = TRK_ACTIVE;
                head_d  = ONE;
            end else begin
                state_d = TRK_DONE;
                head_d  = NIL;
            end
        end else begin
            unique case (state_q)
                TRK_IDLE:   state_d = TRK_IDLE;
                TRK_ACTIVE: begin
                    if (removes_front) begin
                        head_d = rd_next;
                        if (rd_next == NIL) state_d = TRK_DONE;
                    end
                end
                TRK_DONE:   state_d = TRK_DONE;
                default:    state_d = TRK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
            head_q  <= NIL;
        end else begin
            state_q <= state_d;
            head_q  <= head_d;
        end
    end

    always_comb begin
        head       = head_q;
        head_valid = 1'b0;
        all_done   = 1'b0;
        unique case (state_q)
            TRK_IDLE:   ;
            TRK_ACTIVE: head_valid = 1'b1;
            TRK_DONE:   all_done   = 1'b1;
            default:    ;
        endcase
    end

    assert_load_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (init_valid && init_count > ONE) |=> (head_q == ONE && state_q == TRK_ACTIVE));

    assert_ignored_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eject_valid && !init_valid && !rd_live) |=> $stable(head_q));

    assert_head_ascends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_valid && state_q == TRK_ACTIVE) |=> (head_q >= $past(head_q)));

    assert_done_sentinel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_DONE) |-> (head_q == NIL));

    assert_idle_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_IDLE && !init_valid) |=> (state_q == TRK_IDLE && head_q == NIL));
endmodule

// File: rtl/unrouted_switch_tracker.sv
module unrouted_switch_tracker #(
    parameter int MAX_SW = 32,
    parameter int IDX_W  = $clog2(MAX_SW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_valid,
    input  logic [IDX_W-1:0] init_count,
    input  logic             eject_valid,
    input  logic [IDX_W-1:0] eject_idx,
    input  logic             head_rd,
    output logic [IDX_W-1:0] head,
    output logic             head_valid,
    output logic             all_done
);
    logic             load, unlink_en, rd_live;
    logic [IDX_W-1:0] load_cnt, unlink_idx, rd_idx, rd_next, rd_prev;

    tracker_fsm #(.MAX_SW(MAX_SW), .IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_valid (init_valid),
        .init_count (init_count),
        .eject_valid(eject_valid),
        .eject_idx  (eject_idx),
        .head_rd    (head_rd),
        .rd_live    (rd_live),
        .rd_next    (rd_next),
        .rd_prev    (rd_prev),
        .load       (load),
        .load_cnt   (load_cnt),
        .unlink_en  (unlink_en),
        .unlink_idx (unlink_idx),
        .rd_idx     (rd_idx),
        .head       (head),
        .head_valid (head_valid),
        .all_done   (all_done)
    );

    tracker_link_store #(.MAX_SW(MAX_SW), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_cnt  (load_cnt),
        .unlink_en (unlink_en),
        .unlink_idx(unlink_idx),
        .rd_idx    (rd_idx),
        .rd_live   (rd_live),
        .rd_next   (rd_next),
        .rd_prev   (rd_prev)
    );

    assert_valid_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(head_valid && all_done));
endmodule

// File: tb/unrouted_switch_tracker_tb.sv
module unrouted_switch_tracker_tb;
    localparam int SW = 8;
    localparam int W  = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         init_valid = 1'b0;
    logic [W-1:0] init_count = '0;
    logic         eject_valid = 1'b0;
    logic [W-1:0] eject_idx = '0;
    logic         head_rd = 1'b0;
    logic [W-1:0] head;
    logic         head_valid, all_done;

    int vectors = 0;
    int misses  = 0;

    logic [SW-1:0] m_live = '0;
    bit            m_started = 1'b0;

    always #10 clk = ~clk;

    unrouted_switch_tracker #(.MAX_SW(SW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .init_valid(init_valid), .init_count(init_count),
        .eject_valid(eject_valid), .eject_idx(eject_idx),
        .head_rd(head_rd),
        .head(head), .head_valid(head_valid), .all_done(all_done)
    );

    function automatic int low_live();
        for (int k = 0; k < SW; k++) if (m_live[k]) return k;
        return SW;
    endfunction

    task automatic check(string tag);
        int  eh;
        bit  ev, ed;
        eh = low_live();
        ev = m_started && (m_live != '0);
        ed = m_started && (m_live == '0);
        vectors++;
        if (int'(head) != eh || head_valid != ev || all_done != ed) begin
            misses++;
            $display("FAIL %s: head=%0d valid=%0b done=%0b expected head=%0d valid=%0b done=%0b",
                     tag, head, head_valid, all_done, eh, ev, ed);
        end
    endtask

    // One cycle of stimulus, model update, then a check at the next falling edge
    task automatic step(bit iv, int ic, bit ev, int ei, bit hr, string tag);
        init_valid  = iv;
        init_count  = W'(ic);
        eject_valid = ev;
        eject_idx   = W'(ei);
        head_rd     = hr;
        if (iv) begin
            int c;
            c = (ic > SW) ? SW : ic;
            m_started = 1'b1;
            m_live = '0;
            for (int k = 1; k < c; k++) m_live[k] = 1'b1;
        end else if (m_started && m_live != '0) begin
            if (ev) begin
                if (ei >= 1 && ei < SW && m_live[ei]) m_live[ei] = 1'b0;
            end else if (hr) begin
                m_live[low_live()] = 1'b0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        init_valid = 1'b0; eject_valid = 1'b0; head_rd = 1'b0;
        check(tag);
    endtask

    initial begin
        #4_000_000;
        misses++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release");

        step(0, 0, 1, 3, 0, "R11 eject before load");
        step(0, 0, 0, 0, 1, "R11 head read before load");

        // R2: every count value including those above MAX_SW
        for (int c = 0; c < 16; c++) step(1, c, 0, 0, 0, "R2 load count");

        // R9: load wins over eject and head read
        step(1, 8, 0, 0, 0, "R2 load 8");
        step(1, 5, 1, 1, 1, "R9 load with eject");
        step(0, 0, 1, 6, 0, "R5 eject beyond count");
        step(0, 0, 1, 4, 0, "R4 eject 4 of 5");

        // R7: eject and head read together
        step(1, 8, 0, 0, 0, "R2 reload");
        step(0, 0, 1, 5, 1, "R7 eject with head read");
        step(0, 0, 0, 0, 1, "R3 head read after R7");

        // Sweep every subset of ejected entries, then drain by head read
        for (int mask = 0; mask < 128; mask++) begin
            step(1, 8, 0, 0, 0, "R2 sweep load");
            step(0, 0, 1, 0, 0, "R5 eject zero");
            for (int i = 1; i < SW; i++) begin
                if (mask[i-1]) begin
                    if (low_live() == i) step(0, 0, 1, i, 0, "R6 eject head");
                    else                 step(0, 0, 1, i, 0, "R4 eject inner");
                end
            end
            step(0, 0, 1, 7 - (mask % 7), 0, "R5 repeat or fresh eject");
            step(0, 0, 1, 12, 0, "R5 out of range");
            for (int d = 0; d < SW; d++) begin
                if (m_live != '0) step(0, 0, 0, 0, 1, "R3 R8 drain");
            end
            step(0, 0, 0, 0, 1, "R10 head read when done");
            step(0, 0, 1, 3, 0, "R10 eject when done");
        end

        // Descending ejects at every count
        for (int c = 2; c <= SW; c++) begin
            step(1, c, 0, 0, 0, "R2 count sweep");
            for (int i = c - 1; i >= 1; i--) step(0, 0, 1, i, 0, "R4 R10 descending");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule